// File: doc/BRIEF.md
# Block Hash Accelerator Register Front End

This block sits between a 32-bit register bus and a block-hash compression engine. Software identifies the core through three read-only words. It fills a message block buffer one 32-bit word at a time. It starts the engine by writing the control register, polls the status register for engine-idle and digest-available, and then reads the digest words. The hash arithmetic lives in a separate engine. This block only presents the block contents, the selected output variant and one-cycle start pulses to that engine, and it takes back a one-cycle completion strobe and the digest bus.

Each register access is a single-cycle strobe (`cs` high, with `we` choosing write or read). Read data appears on `rdata` in the cycle after the read strobe and holds until the next read. There are two start commands. One opens a new message with its first block. The other continues the message with each following block. A two-bit variant field, captured when a command is accepted, tells the engine which truncated output form to produce. While the engine is working, the block buffer and the control register are locked against writes. This keeps the data under compression stable.

Top module: `hash_front`

## Requirements
- R1: After reset, status reads 1 (idle set, digest-available clear), the control register reads 0x0000000C (variant 3), every block word reads 0, and neither start pulse is high.
- R2: Reads of address 0x00, 0x01 and 0x02 return the NAME0, NAME1 and VERSION parameters. Writes to them change nothing. A read of an address that maps to nothing returns 0. Read data is valid in the cycle after the read strobe.
- R3: A write to the control register at 0x08 while idle, with bit 0 set, raises `eng_init` for exactly the one cycle after the write. With only bit 1 set, it raises `eng_next` instead. With both bits set, only `eng_init` rises.
- R4: An accepted control write copies bits 3:2 into the variant. The variant drives `eng_mode` with the encoding 0 = 512/224, 1 = 512/256, 2 = 384, 3 = 512. A read of 0x08 returns the variant in bits 3:2 and zeros in every other bit.
- R5: The status register at 0x09 holds idle in bit 0 and digest-available in bit 1. An accepted start command clears both bits in the same cycle that its pulse is high.
- R6: `eng_done` while idle is low sets both idle and digest-available in the next cycle. `eng_done` while idle is high changes nothing.
- R7: A control write while idle is low is ignored: no start pulse, and the variant is unchanged.
- R8: Block word i (0 <= i < BLOCK_WORDS) is written and read at address 0x10 + i. It drives `eng_block` bits [(BLOCK_WORDS-1-i)*32 +: 32], so word 0 is the most significant.
- R9: Block word writes while idle is low are ignored.
- R10: Digest word j (0 <= j < DIGEST_WORDS) reads at address 0x40 + j and returns `eng_digest` bits [(DIGEST_WORDS-1-j)*32 +: 32] while digest-available is set. It returns 0 while digest-available is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read strobe |
| eng_init | output | 1 | One-cycle start of the first block of a message |
| eng_next | output | 1 | One-cycle start of a following block |
| eng_mode | output | 2 | Output variant selection |
| eng_block | output | BLOCK_WORDS*32 | Message block, word 0 most significant |
| eng_done | input | 1 | One-cycle completion strobe from the engine |
| eng_digest | input | DIGEST_WORDS*32 | Digest from the engine, word 0 most significant |

## Verification
The hardest situation to reach is a write that arrives while the engine is still busy. Such a write must leave the block buffer, the variant and the pulse outputs exactly as they were. The bench reaches it by issuing an accepted start command and then holding back the completion strobe. It writes a conflicting control word and a conflicting block word during that window. It then checks `eng_next`, `eng_mode`, the `eng_block` slice and the readback before it releases the completion strobe. A completion strobe sent while idle, and a digest read made while busy, are exercised the same way, by choosing when the bench plays the engine's part.

// File: rtl/hash_front_pkg.sv
package hash_front_pkg;

    localparam int unsigned WORD_W = 32;

    // Fixed register map (the neighbouring software decodes these)
    localparam int unsigned REG_NAME0   = 'h00;
    localparam int unsigned REG_NAME1   = 'h01;
    localparam int unsigned REG_VERSION = 'h02;
    localparam int unsigned REG_CTRL    = 'h08;
    localparam int unsigned REG_STATUS  = 'h09;

    // Control and status bit positions
    localparam int unsigned CTRL_INIT_BIT = 0;
    localparam int unsigned CTRL_NEXT_BIT = 1;
    localparam int unsigned CTRL_MODE_LO  = 2;
    localparam int unsigned STAT_IDLE_BIT = 0;
    localparam int unsigned STAT_AVAIL_BIT = 1;

    typedef enum logic [1:0] {
        VAR_T224 = 2'd0,
        VAR_T256 = 2'd1,
        VAR_384  = 2'd2,
        VAR_FULL = 2'd3
    } variant_e;

    typedef struct packed {
        logic     idle;
        logic     avail;
        variant_e mode;
        logic     init_p;
        logic     next_p;
    } cmd_state_t;

endpackage

// File: rtl/hash_front_cmd.sv
module hash_front_cmd
    import hash_front_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_wr,
    input  logic [3:0] ctrl_bits,
    input  logic     eng_done,
    output logic     idle,
    output logic     avail,
    output variant_e mode,
    output logic     init_p,
    output logic     next_p
);

    cmd_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.init_p = 1'b0;
        state_d.next_p = 1'b0;
        if (!state_q.idle) begin
            if (eng_done) begin
                state_d.idle  = 1'b1;
                state_d.avail = 1'b1;
            end
        end else if (ctrl_wr) begin
            state_d.mode = variant_e'(ctrl_bits[CTRL_MODE_LO +: 2]);
            if (ctrl_bits[CTRL_INIT_BIT]) begin
                state_d.init_p = 1'b1;
                state_d.idle   = 1'b0;
                state_d.avail  = 1'b0;
            end else if (ctrl_bits[CTRL_NEXT_BIT]) begin
                state_d.next_p = 1'b1;
                state_d.idle   = 1'b0;
                state_d.avail  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.idle   <= 1'b1;
            state_q.avail  <= 1'b0;
            state_q.mode   <= VAR_FULL;
            state_q.init_p <= 1'b0;
            state_q.next_p <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign idle   = state_q.idle;
    assign avail  = state_q.avail;
    assign mode   = state_q.mode;
    assign init_p = state_q.init_p;
    assign next_p = state_q.next_p;

endmodule

// File: rtl/hash_front_blkbuf.sv
module hash_front_blkbuf
    import hash_front_pkg::*;
#(
    parameter int unsigned WORDS = 32,
    localparam int unsigned IDX_W = $clog2(WORDS),
    localparam int unsigned BUF_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              accept,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [BUF_W-1:0]  words
);

    typedef struct packed {
        logic [BUF_W-1:0] bits;
    } buf_state_t;

    buf_state_t buf_d, buf_q;
    logic [WORDS-1:0] word_we;

    for (genvar g = 0; g < WORDS; g++) begin : g_we
        assign word_we[g] = wr_en && accept && (idx == IDX_W'(g));
    end

    always_comb begin
        buf_d = buf_q;
        for (int i = 0; i < int'(WORDS); i++) begin
            if (word_we[i]) begin
                buf_d.bits[(int'(WORDS) - 1 - i) * WORD_W +: WORD_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign words = buf_q.bits;

endmodule

// File: rtl/hash_front_rdmux.sv
module hash_front_rdmux
    import hash_front_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned BLOCK_WORDS  = 32,
    parameter int unsigned DIGEST_WORDS = 16,
    parameter logic [31:0] NAME0        = 32'h0,
    parameter logic [31:0] NAME1        = 32'h0,
    parameter logic [31:0] VERSION      = 32'h0,
    localparam int unsigned BLK_IDX_W   = $clog2(BLOCK_WORDS),
    localparam int unsigned DIG_IDX_W   = $clog2(DIGEST_WORDS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           blk_hit,
    input  logic [BLK_IDX_W-1:0]           blk_idx,
    input  logic                           dig_hit,
    input  logic [DIG_IDX_W-1:0]           dig_idx,
    input  logic                           idle,
    input  logic                           avail,
    input  variant_e                       mode,
    input  logic [BLOCK_WORDS*WORD_W-1:0]  blk_words,
    input  logic [DIGEST_WORDS*WORD_W-1:0] dig_words,
    output logic [WORD_W-1:0]              rdata
);

    typedef struct packed {
        logic [WORD_W-1:0] data;
    } rd_state_t;

    rd_state_t rd_d, rd_q;
    logic [WORD_W-1:0] sel;

    always_comb begin
        sel = '0;
        if (blk_hit) begin
            sel = blk_words[(int'(BLOCK_WORDS) - 1 - int'(blk_idx)) * WORD_W +: WORD_W];
        end else if (dig_hit) begin
            if (avail) begin
                sel = dig_words[(int'(DIGEST_WORDS) - 1 - int'(dig_idx)) * WORD_W +: WORD_W];
            end
        end else if (addr == ADDR_W'(REG_NAME0)) begin
            sel = NAME0;
        end else if (addr == ADDR_W'(REG_NAME1)) begin
            sel = NAME1;
        end else if (addr == ADDR_W'(REG_VERSION)) begin
            sel = VERSION;
        end else if (addr == ADDR_W'(REG_CTRL)) begin
            sel = {{(WORD_W-4){1'b0}}, mode, 2'b00};
        end else if (addr == ADDR_W'(REG_STATUS)) begin
            sel = '0;
            sel[STAT_IDLE_BIT]  = idle;
            sel[STAT_AVAIL_BIT] = avail;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.data = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.data;

endmodule

// File: rtl/hash_front.sv
module hash_front
    import hash_front_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned BLOCK_WORDS  = 32,
    parameter int unsigned DIGEST_WORDS = 16,
    parameter int unsigned BLOCK_BASE   = 'h10,
    parameter int unsigned DIGEST_BASE  = 'h40,
    parameter logic [31:0] NAME0        = 32'h6861_7368,
    parameter logic [31:0] NAME1        = 32'h2d35_3132,
    parameter logic [31:0] VERSION      = 32'h3031_3030
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cs,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [31:0]                    wdata,
    output logic [31:0]                    rdata,
    output logic                           eng_init,
    output logic                           eng_next,
    output logic [1:0]                     eng_mode,
    output logic [BLOCK_WORDS*32-1:0]      eng_block,
    input  logic                           eng_done,
    input  logic [DIGEST_WORDS*32-1:0]     eng_digest
);

    localparam int unsigned BLK_IDX_W = $clog2(BLOCK_WORDS);
    localparam int unsigned DIG_IDX_W = $clog2(DIGEST_WORDS);
    localparam logic [ADDR_W-1:0] BLK_LO = ADDR_W'(BLOCK_BASE);
    localparam logic [ADDR_W-1:0] BLK_HI = ADDR_W'(BLOCK_BASE + BLOCK_WORDS);
    localparam logic [ADDR_W-1:0] DIG_LO = ADDR_W'(DIGEST_BASE);
    localparam logic [ADDR_W-1:0] DIG_HI = ADDR_W'(DIGEST_BASE + DIGEST_WORDS);

    logic                 wr_strobe, rd_strobe;
    logic                 blk_hit, dig_hit, ctrl_hit;
    logic [BLK_IDX_W-1:0] blk_idx;
    logic [DIG_IDX_W-1:0] dig_idx;
    logic                 st_idle, st_avail;
    variant_e             st_mode;

    assign wr_strobe = cs && we;
    assign rd_strobe = cs && !we;
    assign blk_hit   = (addr >= BLK_LO) && (addr < BLK_HI);
    assign dig_hit   = (addr >= DIG_LO) && (addr < DIG_HI);
    assign ctrl_hit  = (addr == ADDR_W'(REG_CTRL));
    assign blk_idx   = BLK_IDX_W'(addr - BLK_LO);
    assign dig_idx   = DIG_IDX_W'(addr - DIG_LO);

    hash_front_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_strobe && ctrl_hit),
        .ctrl_bits (wdata[3:0]),
        .eng_done  (eng_done),
        .idle      (st_idle),
        .avail     (st_avail),
        .mode      (st_mode),
        .init_p    (eng_init),
        .next_p    (eng_next)
    );

    hash_front_blkbuf #(
        .WORDS (BLOCK_WORDS)
    ) u_blkbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_strobe && blk_hit),
        .accept (st_idle),
        .idx    (blk_idx),
        .wdata  (wdata),
        .words  (eng_block)
    );

    hash_front_rdmux #(
        .ADDR_W       (ADDR_W),
        .BLOCK_WORDS  (BLOCK_WORDS),
        .DIGEST_WORDS (DIGEST_WORDS),
        .NAME0        (NAME0),
        .NAME1        (NAME1),
        .VERSION      (VERSION)
    ) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_strobe),
        .addr      (addr),
        .blk_hit   (blk_hit),
        .blk_idx   (blk_idx),
        .dig_hit   (dig_hit),
        .dig_idx   (dig_idx),
        .idle      (st_idle),
        .avail     (st_avail),
        .mode      (st_mode),
        .blk_words (eng_block),
        .dig_words (eng_digest),
        .rdata     (rdata)
    );

    assign eng_mode = st_mode;

endmodule

// File: rtl/hash_front_chk.sv
module hash_front_chk #(
    parameter int unsigned BLOCK_W = 1024
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ready,
    input logic               valid,
    input logic               eng_init,
    input logic               eng_next,
    input logic [1:0]         eng_mode,
    input logic [BLOCK_W-1:0] eng_block,
    input logic               eng_done
);

    p_init_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_init |=> !eng_init);

    p_next_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_next |=> !eng_next);

    p_single_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_init || eng_next) |-> !(eng_init && eng_next));

    p_cmd_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_init || eng_next) |-> $past(ready));

    p_busy_on_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_init || eng_next) |-> (!ready && !valid));

    p_no_avail_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !valid);

    p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && eng_done) |=> (ready && valid));

    p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !eng_done) |=> !ready);

    p_block_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(eng_block));

    p_mode_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(eng_mode));

endmodule

bind hash_front hash_front_chk #(
    .BLOCK_W (BLOCK_WORDS * 32)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (st_idle),
    .valid     (st_avail),
    .eng_init  (eng_init),
    .eng_next  (eng_next),
    .eng_mode  (eng_mode),
    .eng_block (eng_block),
    .eng_done  (eng_done)
);

// File: tb/test_hash_front.sv
module test_hash_front;

    localparam int BW = 32;
    localparam int DW = 16;
    localparam int BLK_BITS = BW * 32;
    localparam int DIG_BITS = DW * 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cs = 1'b0;
    logic                we = 1'b0;
    logic [7:0]          addr = '0;
    logic [31:0]         wdata = '0;
    logic [31:0]         rdata;
    logic                eng_init, eng_next;
    logic [1:0]          eng_mode;
    logic [BLK_BITS-1:0] eng_block;
    logic                eng_done = 1'b0;
    logic [DIG_BITS-1:0] eng_digest = '0;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    hash_front i_hash_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .we         (we),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .eng_init   (eng_init),
        .eng_next   (eng_next),
        .eng_mode   (eng_mode),
        .eng_block  (eng_block),
        .eng_done   (eng_done),
        .eng_digest (eng_digest)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        cs = 1'b0;
        d = rdata;
    endtask

    task automatic done_strobe();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    function automatic logic [31:0] blk_word(input int i);
        return eng_block[(BW - 1 - i) * 32 +: 32];
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 init pulse", {31'b0, eng_init}, 32'h0);
        chk("R1 next pulse", {31'b0, eng_next}, 32'h0);
        rd(8'h09, v); chk("R1 status", v, 32'h1);
        rd(8'h08, v); chk("R1 ctrl", v, 32'hC);
        rd(8'h10, v); chk("R1 block word", v, 32'h0);
        chk("R1 eng_mode", {30'b0, eng_mode}, 32'h3);
    endtask

    task automatic t_ident();
        logic [31:0] v;
        rd(8'h00, v); chk("R2 name0", v, 32'h6861_7368);
        rd(8'h01, v); chk("R2 name1", v, 32'h2d35_3132);
        rd(8'h02, v); chk("R2 version", v, 32'h3031_3030);
        wr(8'h00, 32'hDEAD_BEEF);
        rd(8'h00, v); chk("R2 name0 after write", v, 32'h6861_7368);
        rd(8'h05, v); chk("R2 unmapped", v, 32'h0);
    endtask

    task automatic t_block();
        logic [31:0] v;
        wr(8'h10, 32'hA0A0_0001);
        wr(8'h2F, 32'hB1B1_001F);
        chk("R8 word0 on bus", blk_word(0), 32'hA0A0_0001);
        chk("R8 word31 on bus", eng_block[31:0], 32'hB1B1_001F);
        rd(8'h10, v); chk("R8 word0 read", v, 32'hA0A0_0001);
        rd(8'h2F, v); chk("R8 word31 read", v, 32'hB1B1_001F);
    endtask

    task automatic t_idle_done();
        logic [31:0] v;
        rd(8'h40, v); chk("R10 digest before avail", v, 32'h0);
        done_strobe();
        rd(8'h09, v); chk("R6 done while idle", v, 32'h1);
    endtask

    task automatic t_init_cmd();
        logic [31:0] v;
        wr(8'h08, 32'h0000_0009);
        chk("R3 init high", {31'b0, eng_init}, 32'h1);
        chk("R3 next low", {31'b0, eng_next}, 32'h0);
        chk("R4 mode 2", {30'b0, eng_mode}, 32'h2);
        @(negedge clk);
        chk("R3 init one cycle", {31'b0, eng_init}, 32'h0);
        rd(8'h09, v); chk("R5 status busy", v, 32'h0);
        rd(8'h08, v); chk("R4 ctrl read", v, 32'h8);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        wr(8'h08, 32'h0000_0002);
        chk("R7 no next when busy", {31'b0, eng_next}, 32'h0);
        chk("R7 mode kept", {30'b0, eng_mode}, 32'h2);
        wr(8'h10, 32'hFFFF_FFFF);
        chk("R9 block kept", blk_word(0), 32'hA0A0_0001);
        rd(8'h10, v); chk("R9 block read kept", v, 32'hA0A0_0001);
    endtask

    task automatic t_done_digest();
        logic [31:0] v;
        for (int j = 0; j < DW; j++) begin
            eng_digest[(DW - 1 - j) * 32 +: 32] = 32'hD000_0000 + 32'(j);
        end
        done_strobe();
        rd(8'h09, v); chk("R6 done sets status", v, 32'h3);
        rd(8'h40, v); chk("R10 digest word0", v, 32'hD000_0000);
        rd(8'h4F, v); chk("R10 digest word15", v, 32'hD000_000F);
    endtask

    task automatic t_next_cmd();
        logic [31:0] v;
        wr(8'h08, 32'h0000_0007);
        chk("R3 both bits init", {31'b0, eng_init}, 32'h1);
        chk("R3 both bits no next", {31'b0, eng_next}, 32'h0);
        done_strobe();
        wr(8'h08, 32'h0000_0006);
        chk("R3 next high", {31'b0, eng_next}, 32'h1);
        chk("R3 init low", {31'b0, eng_init}, 32'h0);
        chk("R4 mode 1", {30'b0, eng_mode}, 32'h1);
        rd(8'h09, v); chk("R5 avail cleared", v, 32'h0);
        rd(8'h40, v); chk("R10 digest hidden busy", v, 32'h0);
        done_strobe();
        wr(8'h10, 32'h1234_5678);
        chk("R8 write after done", blk_word(0), 32'h1234_5678);
    endtask

    initial begin
        t_reset();
        t_ident();
        t_block();
        t_idle_done();
        t_init_cmd();
        t_busy_ignore();
        t_done_digest();
        t_next_cmd();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule